// File: doc/BRIEF.md
# Stream Consumer Port Interface

This block sits between one local output port of a streaming switch and the input of a computing module. On the switch side it answers a connection request with an acknowledge, throws away the routing header that opens the connection, and stores the data words that follow in a two-clock FIFO. Only words whose valid flag is set are stored. While the connection is open, the FIFO's fill level is sent back to the sender on a single full wire, so the sender pauses before the buffer overflows.

On the module side the block shows the oldest stored word, an end-of-stream flag for that word, and a ready flag. The module takes a word by raising its read enable. When the switch drops the request, the connection closes. Words already in the buffer can still be read after that. The switch side and the module side run on separate clocks. Pointers cross between them through Gray-coded synchronisers.

A link word is `LINK_W` bits wide. Bit `LINK_W-1` is the valid (write) flag. Bit `LINK_W-2` is the end-of-stream flag. The lower `LINK_W-2` bits are payload.

Top module: `sccon_port`

## Requirements
- R1: While the switch-side reset is applied, and on the first cycle after it, `link_ack_o` and `link_rfull_o` are 0. `md_rdy_o` and `md_eos_o` are 0 after the module-side reset.
- R2: When the port is idle and samples `link_req_i` = 1 on a switch clock edge, `link_ack_o` is 1 from that edge on.
- R3: The word on `link_word_i` in the cycle the request is first sampled is the header. It is never stored.
- R4: While the connection is open, a word is stored only if its bit `LINK_W-1` is 1. Words with that bit at 0 are discarded.
- R5: `md_rdy_o` is 1 whenever a stored word is visible on the module side. `md_data_o` then carries that word's payload (bits `LINK_W-3:0`), and words leave in the order they were stored.
- R6: When `md_rd_en_i` = 1 and `md_rdy_o` = 1, one word is removed at the module clock edge. A read enable while `md_rdy_o` = 0 has no effect.
- R7: `md_eos_o` equals bit `LINK_W-2` of the head word while `md_rdy_o` = 1, and is 0 otherwise.
- R8: `link_rfull_o` is 1 when the writer's view of the fill level is at least `2**ADDR_W - 1`.
- R9: A valid word that arrives while the FIFO holds `2**ADDR_W` entries is dropped. Stored words are never overwritten.
- R10: When `link_req_i` is sampled 0 while the connection is open, `link_ack_o` falls on that edge and the port returns to idle. Words already stored stay readable.
- R11: With unrelated switch and module clocks, every accepted word reaches the module exactly once, in order.
- R12: While the port is idle, words on `link_word_i` are ignored even when their valid bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sw_clk | input | 1 | Switch-side clock |
| sw_rst | input | 1 | Switch-side synchronous reset, active high |
| link_req_i | input | 1 | Connection request from the switch |
| link_word_i | input | LINK_W | Link word: valid flag, end-of-stream flag, payload |
| link_ack_o | output | 1 | Connection acknowledge to the switch |
| link_rfull_o | output | 1 | Backpressure to the sender (almost full) |
| md_clk | input | 1 | Module-side clock |
| md_rst | input | 1 | Module-side synchronous reset, active high |
| md_rdy_o | output | 1 | A stored word is available |
| md_rd_en_i | input | 1 | Module takes the head word |
| md_data_o | output | LINK_W-2 | Payload of the head word |
| md_eos_o | output | 1 | End-of-stream flag of the head word |

## Verification
If the connection state is wrong, it shows as `link_ack_o` being wrong on the very next switch edge. A wrong write pointer or a missed valid-bit qualification shows on the module side two module edges later: the wrong word appears, a word is missing, or `md_rdy_o` rises when it should not. A wrong read-pointer view on the write side shows within two switch edges, as `link_rfull_o` changing at the wrong fill level or a word being dropped that should have been kept. The bench keeps both clocks equal at first so that all of these can be compared cycle by cycle. It then checks only ordering and completeness under unrelated clocks.

// File: rtl/sccon_pkg.sv
package sccon_pkg;

    // Width of the helper Gray functions; pointers are zero-extended to it.
    localparam int GRAY_W = 16;

    typedef enum logic [0:0] {
        LINK_IDLE = 1'b0,
        LINK_OPEN = 1'b1
    } link_state_e;

    // Decoded control flags of a link word.
    typedef struct packed {
        logic valid;
        logic eos;
    } link_flags_t;

    function automatic logic [GRAY_W-1:0] bin_to_gray(input logic [GRAY_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_W-1:0] gray_to_bin(input logic [GRAY_W-1:0] g);
        logic [GRAY_W-1:0] b;
        b[GRAY_W-1] = g[GRAY_W-1];
        for (int i = GRAY_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/sccon_gray_sync.sv
module sccon_gray_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sccon_async_fifo.sv
module sccon_async_fifo
    import sccon_pkg::*;
#(
    parameter int DATA_W = 15,
    parameter int ADDR_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              push_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              full_o,
    output logic              afull_o,
    output logic [ADDR_W:0]   wlevel_o,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              pop_i,
    output logic              empty_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // write domain
    logic [PTR_W-1:0] wbin_q, wgray_q, rgray_in_w;
    logic [PTR_W-1:0] wbin_nxt, wgray_nxt, rbin_in_w;
    logic [GRAY_W-1:0] wg_ext, rb_ext;
    logic wr_take;

    always_comb begin
        wbin_nxt  = wbin_q + PTR_W'(1);
        wg_ext    = bin_to_gray(GRAY_W'(wbin_nxt));
        wgray_nxt = wg_ext[PTR_W-1:0];
        rb_ext    = gray_to_bin(GRAY_W'(rgray_in_w));
        rbin_in_w = rb_ext[PTR_W-1:0];
        wlevel_o  = wbin_q - rbin_in_w;
        full_o    = (wlevel_o == PTR_W'(DEPTH));
        afull_o   = (wlevel_o >= PTR_W'(DEPTH - 1));
        wr_take   = push_i && !full_o;
    end

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (wr_take) begin
            wbin_q  <= wbin_nxt;
            wgray_q <= wgray_nxt;
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_take) mem[wbin_q[ADDR_W-1:0]] <= wdata_i;
    end

    // read domain
    logic [PTR_W-1:0] rbin_q, rgray_q, wgray_in_r;
    logic [PTR_W-1:0] rbin_nxt, rgray_nxt;
    logic [GRAY_W-1:0] rg_ext;
    logic rd_take;

    always_comb begin
        rbin_nxt  = rbin_q + PTR_W'(1);
        rg_ext    = bin_to_gray(GRAY_W'(rbin_nxt));
        rgray_nxt = rg_ext[PTR_W-1:0];
        empty_o   = (rgray_q == wgray_in_r);
        rd_take   = pop_i && !empty_o;
        rdata_o   = mem[rbin_q[ADDR_W-1:0]];
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else if (rd_take) begin
            rbin_q  <= rbin_nxt;
            rgray_q <= rgray_nxt;
        end
    end

    sccon_gray_sync #(.WIDTH(PTR_W), .STAGES(SYNC_N)) u_w2r (
        .clk (rclk),
        .rst (rrst),
        .d_i (wgray_q),
        .q_o (wgray_in_r)
    );

    sccon_gray_sync #(.WIDTH(PTR_W), .STAGES(SYNC_N)) u_r2w (
        .clk (wclk),
        .rst (wrst),
        .d_i (rgray_q),
        .q_o (rgray_in_w)
    );
endmodule

// File: rtl/sccon_link_ctrl.sv
module sccon_link_ctrl
    import sccon_pkg::*;
#(
    parameter int LINK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [LINK_W-1:0] word_i,
    output logic              ack_o,
    output logic              push_o,
    output logic [LINK_W-2:0] push_data_o
);
    link_state_e state_q, state_d;
    link_flags_t flags;

    always_comb begin
        flags.valid = word_i[LINK_W-1];
        flags.eos   = word_i[LINK_W-2];
        state_d     = state_q;
        unique case (state_q)
            LINK_IDLE: if (req_i)  state_d = LINK_OPEN;
            LINK_OPEN: if (!req_i) state_d = LINK_IDLE;
            default:               state_d = LINK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LINK_IDLE;
        else     state_q <= state_d;
    end

    // The header arrives while still idle, so it never reaches the FIFO.
    assign push_o      = (state_q == LINK_OPEN) && req_i && flags.valid;
    assign push_data_o = {flags.eos, word_i[LINK_W-3:0]};
    assign ack_o       = (state_q == LINK_OPEN);
endmodule

// File: rtl/sccon_port.sv
module sccon_port
    import sccon_pkg::*;
#(
    parameter int LINK_W = 16,
    parameter int ADDR_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic              sw_clk,
    input  logic              sw_rst,
    input  logic              link_req_i,
    input  logic [LINK_W-1:0] link_word_i,
    output logic              link_ack_o,
    output logic              link_rfull_o,
    input  logic              md_clk,
    input  logic              md_rst,
    output logic              md_rdy_o,
    input  logic              md_rd_en_i,
    output logic [LINK_W-3:0] md_data_o,
    output logic              md_eos_o
);
    localparam int STORE_W = LINK_W - 1;

    logic               push_w;
    logic [STORE_W-1:0] push_data_w;
    logic               fifo_full_w;
    logic               fifo_afull_w;
    logic [ADDR_W:0]    wlevel_w;
    logic               fifo_empty_w;
    logic [STORE_W-1:0] head_w;

    sccon_link_ctrl #(.LINK_W(LINK_W)) u_ctrl (
        .clk         (sw_clk),
        .rst         (sw_rst),
        .req_i       (link_req_i),
        .word_i      (link_word_i),
        .ack_o       (link_ack_o),
        .push_o      (push_w),
        .push_data_o (push_data_w)
    );

    sccon_async_fifo #(.DATA_W(STORE_W), .ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) u_fifo (
        .wclk     (sw_clk),
        .wrst     (sw_rst),
        .push_i   (push_w),
        .wdata_i  (push_data_w),
        .full_o   (fifo_full_w),
        .afull_o  (fifo_afull_w),
        .wlevel_o (wlevel_w),
        .rclk     (md_clk),
        .rrst     (md_rst),
        .pop_i    (md_rd_en_i),
        .empty_o  (fifo_empty_w),
        .rdata_o  (head_w)
    );

    assign link_rfull_o = fifo_afull_w;
    assign md_rdy_o     = !fifo_empty_w;
    assign md_data_o    = head_w[LINK_W-3:0];
    assign md_eos_o     = !fifo_empty_w && head_w[STORE_W-1];
endmodule

// File: rtl/sccon_port_chk.sv
module sccon_port_chk #(
    parameter int PTR_W = 4
) (
    input logic             sw_clk,
    input logic             sw_rst,
    input logic             md_clk,
    input logic             md_rst,
    input logic             link_req_i,
    input logic             link_ack_o,
    input logic             md_rdy_o,
    input logic             md_eos_o,
    input logic             push_w,
    input logic             fifo_full_w,
    input logic [PTR_W-1:0] wlevel_w
);
    // R1
    rst_quiet_chk: assert property (@(posedge sw_clk)
        $past(sw_rst) |-> !link_ack_o);

    // R2
    ack_rise_chk: assert property (@(posedge sw_clk) disable iff (sw_rst)
        (!link_ack_o && link_req_i) |=> link_ack_o);

    // R10
    ack_fall_chk: assert property (@(posedge sw_clk) disable iff (sw_rst)
        (link_ack_o && !link_req_i) |=> !link_ack_o);

    // R4
    push_open_chk: assert property (@(posedge sw_clk) disable iff (sw_rst)
        push_w |-> link_ack_o);

    // R9
    no_overflow_chk: assert property (@(posedge sw_clk) disable iff (sw_rst)
        (push_w && fifo_full_w) |=> (wlevel_w <= $past(wlevel_w)));

    // R7
    eos_idle_chk: assert property (@(posedge md_clk) disable iff (md_rst)
        !md_rdy_o |-> !md_eos_o);
endmodule

bind sccon_port sccon_port_chk #(.PTR_W(ADDR_W + 1)) chk_i (
    .sw_clk      (sw_clk),
    .sw_rst      (sw_rst),
    .md_clk      (md_clk),
    .md_rst      (md_rst),
    .link_req_i  (link_req_i),
    .link_ack_o  (link_ack_o),
    .md_rdy_o    (md_rdy_o),
    .md_eos_o    (md_eos_o),
    .push_w      (push_w),
    .fifo_full_w (fifo_full_w),
    .wlevel_w    (wlevel_w)
);

// File: tb/sccon_port_tb.sv
`timescale 1ns/1ps
module sccon_port_tb_top;
    localparam int W     = 16;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, clk_b = 1'b0, phase_b = 1'b0;
    always #4    clk   = ~clk;
    always #5.5  clk_b = ~clk_b;
    wire md_clk = phase_b ? clk_b : clk;

    logic         sw_rst = 1'b1, md_rst = 1'b1;
    logic         link_req = 1'b0;
    logic [W-1:0] link_word = '0;
    logic         md_rd_en = 1'b0;
    logic         link_ack, link_rfull, md_rdy, md_eos;
    logic [W-3:0] md_data;

    sccon_port #(.LINK_W(W), .ADDR_W(AW), .SYNC_N(2)) dut_i (
        .sw_clk(clk), .sw_rst(sw_rst), .link_req_i(link_req), .link_word_i(link_word),
        .link_ack_o(link_ack), .link_rfull_o(link_rfull),
        .md_clk(md_clk), .md_rst(md_rst), .md_rdy_o(md_rdy), .md_rd_en_i(md_rd_en),
        .md_data_o(md_data), .md_eos_o(md_eos)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    function automatic logic [W-1:0] mk(input logic v, input logic e, input logic [W-3:0] p);
        return {v, e, p};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- cycle reference model (equal clocks only) ----------------
    logic [W-2:0] m_q[$];
    bit m_open = 0;
    int m_wr = 0, m_rd = 0, m_wq1 = 0, m_wq2 = 0, m_rq1 = 0, m_rq2 = 0;
    bit cmp_en = 0;

    always @(posedge clk) begin
        int lvl, vis, nwr, nrd;
        if (!phase_b) begin
            if (sw_rst) begin
                m_q.delete();
                m_open = 0; m_wr = 0; m_rd = 0;
                m_wq1 = 0; m_wq2 = 0; m_rq1 = 0; m_rq2 = 0;
                cmp_en = 1;
            end else begin
                lvl = m_wr - m_rq2;
                vis = m_wq2 - m_rd;
                nwr = m_wr; nrd = m_rd;
                if (m_open && link_req && link_word[W-1] && lvl < DEPTH) begin
                    m_q.push_back(link_word[W-2:0]);
                    nwr++;
                end
                if (md_rd_en && vis > 0) begin
                    void'(m_q.pop_front());
                    nrd++;
                end
                if (!m_open && link_req) m_open = 1;
                else if (m_open && !link_req) m_open = 0;
                m_wq2 = m_wq1; m_wq1 = m_wr; m_wr = nwr;
                m_rq2 = m_rq1; m_rq1 = m_rd; m_rd = nrd;
            end
        end
    end

    always @(negedge clk) begin
        bit e_rdy, e_full;
        if (!phase_b && cmp_en) begin
            e_rdy  = (m_wq2 - m_rd) > 0;
            e_full = (m_wr - m_rq2) >= DEPTH - 1;
            check(link_ack == m_open, "R2/R10 ack", link_ack, m_open);
            check(link_rfull == e_full, "R8 rfull", link_rfull, e_full);
            check(md_rdy == e_rdy, "R5 rdy", md_rdy, e_rdy);
            if (e_rdy) begin
                check(md_data == m_q[0][W-3:0], "R5 head data", md_data, m_q[0][W-3:0]);
                check(md_eos == m_q[0][W-2], "R7 eos", md_eos, m_q[0][W-2]);
            end else begin
                check(md_eos == 1'b0, "R7 eos idle", md_eos, 0);
            end
        end
    end

    // ---------------- helpers ----------------
    logic [W-2:0] got[$];

    task automatic drain();
        int quiet = 0;
        got.delete();
        while (quiet < 4) begin
            @(negedge clk);
            if (md_rdy) begin
                got.push_back({md_eos, md_data});
                md_rd_en = 1'b1;
                quiet = 0;
            end else begin
                md_rd_en = 1'b0;
                quiet++;
            end
        end
        md_rd_en = 1'b0;
    endtask

    task automatic send(input logic [W-1:0] w);
        @(negedge clk);
        link_word = w;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(link_ack == 0, "R1 ack", link_ack, 0);
        check(link_rfull == 0, "R1 rfull", link_rfull, 0);
        check(md_rdy == 0, "R1 rdy", md_rdy, 0);
        sw_rst = 0; md_rst = 0;

        // R12 idle words ignored
        for (int i = 0; i < 3; i++) send(mk(1, 0, 14'(16'h0050 + i)));
        send('0);
        repeat (4) @(negedge clk);
        check(md_rdy == 0, "R12 idle words stored", md_rdy, 0);
        check(link_ack == 0, "R12 ack while idle", link_ack, 0);

        // R2/R3/R4/R7 open, header, gap word, eos
        link_req = 1'b1;
        link_word = mk(1, 0, 14'h03AA);
        @(negedge clk);
        check(link_ack == 1, "R2 ack after req", link_ack, 1);
        link_word = mk(1, 0, 14'h0101);
        send(mk(0, 0, 14'h00BD));
        send(mk(1, 0, 14'h0102));
        send(mk(1, 1, 14'h0103));
        send('0);
        drain();
        check(got.size() == 3, "R4 stored count", got.size(), 3);
        if (got.size() == 3) begin
            check(got[0][W-3:0] == 14'h0101, "R3 first word not header", got[0][W-3:0], 14'h0101);
            check(got[1][W-3:0] == 14'h0102, "R4 gap word skipped", got[1][W-3:0], 14'h0102);
            check(got[2][W-2] == 1'b1, "R7 eos on last", got[2][W-2], 1);
            check(got[0][W-2] == 1'b0, "R7 no eos on first", got[0][W-2], 0);
        end

        // R8/R9 overfill without reading
        for (int i = 0; i < 11; i++) send(mk(1, 0, 14'(16'h0200 + i)));
        send('0);
        repeat (4) @(negedge clk);
        check(link_rfull == 1, "R8 rfull at fill", link_rfull, 1);
        // R10 close with data held
        link_req = 1'b0;
        @(negedge clk);
        check(link_ack == 0, "R10 ack falls", link_ack, 0);
        drain();
        check(got.size() == DEPTH, "R9 kept entries", got.size(), DEPTH);
        for (int i = 0; i < got.size() && i < DEPTH; i++)
            check(got[i][W-3:0] == 14'(16'h0200 + i), "R10 readable after close",
                  got[i][W-3:0], 16'h0200 + i);
        check(link_rfull == 0, "R8 rfull clears", link_rfull, 0);

        // R6 read enable on empty
        md_rd_en = 1'b1;
        repeat (3) @(negedge clk);
        md_rd_en = 1'b0;
        check(md_rdy == 0, "R6 pop on empty", md_rdy, 0);
        send(mk(1, 0, 14'h0111));
        link_req = 1'b1; link_word = mk(1, 0, 14'h03BB);
        send(mk(1, 0, 14'h0120));
        send('0);
        drain();
        check(got.size() == 1, "R6 no phantom entry", got.size(), 1);
        if (got.size() == 1)
            check(got[0][W-3:0] == 14'h0120, "R6 entry intact", got[0][W-3:0], 14'h0120);
        link_req = 1'b0;

        // ---------------- R11 unrelated clocks ----------------
        @(negedge clk);
        sw_rst = 1; md_rst = 1; phase_b = 1;
        repeat (8) @(negedge clk);
        sw_rst = 0; md_rst = 0;
        got.delete();
        fork
            begin
                int i = 0;
                @(negedge clk);
                link_req = 1'b1; link_word = mk(1, 0, 14'h03CC);
                while (i < 40) begin
                    @(negedge clk);
                    if (!link_rfull) begin
                        link_word = mk(1, i == 39, 14'(16'h1000 + i));
                        i++;
                    end else begin
                        link_word = '0;
                    end
                end
                @(negedge clk);
                link_word = '0;
            end
            begin
                int tick = 0;
                while (got.size() < 40) begin
                    @(negedge clk_b);
                    tick++;
                    if (md_rdy && tick[0]) begin
                        got.push_back({md_eos, md_data});
                        md_rd_en = 1'b1;
                    end else begin
                        md_rd_en = 1'b0;
                    end
                end
                @(negedge clk_b);
                md_rd_en = 1'b0;
            end
        join
        link_req = 1'b0;
        repeat (6) @(negedge clk_b);
        check(md_rdy == 0, "R11 nothing extra", md_rdy, 0);
        for (int i = 0; i < 40; i++)
            check(got[i][W-3:0] == 14'(16'h1000 + i), "R11 order", got[i][W-3:0], 16'h1000 + i);
        check(got[39][W-2] == 1'b1, "R11 eos last", got[39][W-2], 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule